// File: doc/BRIEF.md
# Receive destination address filter

This block watches the start of every received Ethernet frame and decides whether the frame is wanted. It collects the six destination address bytes as they stream in. From them it forms one accept or reject verdict, using five sources: a global enable, a promiscuous override, a programmed station address, broadcast detection and a 64-bin multicast hash table. The verdict is a single-cycle strobe with an accept flag. Downstream receive logic uses it to keep or drop the frame.

Software sets the block up through a small write-only register port. There is one configuration word, three station address words and four hash words. The multicast hash index is taken from a reflected CRC-32 that is built up byte by byte while the address arrives. No second pass over the header is needed, and the verdict comes out one cycle after the sixth byte.

Top module: `rx_dest_filter`

## Requirements
- R1: While configuration bit 0 (enable, register address 0) is clear, every verdict is a reject, including broadcast and promiscuous cases.
- R2: With enable set and configuration bit 6 (promiscuous) set, every frame is accepted.
- R3: A destination equal to the station address is accepted. Register 1 holds bytes 0 and 1, register 2 holds bytes 2 and 3, and register 3 holds bytes 4 and 5. Bits 15:8 of each register hold the byte that arrives first.
- R4: With enable set, a destination of all ones (FF in all six bytes) is accepted.
- R5: When configuration bit 11 (hash enable) is clear, a destination that is neither the station address nor broadcast is rejected, unless the promiscuous bit is set.
- R6: With hash enable set, the hash index is bits 31:26 of a reflected CRC-32 (polynomial 0xEDB88320, preset all ones, no final inversion). The CRC is fed the six destination bytes in arrival order, least significant bit first. Index bits 3:0 select a bit in the chosen hash word, and a set bit means accept.
- R7: Index bits 5:4 equal to k select the hash word at register address 7-k. Register 7 therefore serves k=0 and register 4 serves k=3.
- R8: Each frame gives exactly one dec_valid pulse, one cycle long. The pulse follows the clock edge that takes the sixth header byte. Bytes after the sixth give no further pulse, and dec_accept is low whenever dec_valid is low.
- R9: in_sof together with in_valid marks byte 0 and restarts header collection, even partway through a header. Cycles with in_valid low between bytes are skipped.
- R10: After reset, dec_valid and dec_accept are low and all configuration, station and hash registers are zero, so frames are rejected.
- R11: Writes to register addresses 8 to 15 have no effect on any verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| in_valid | input | 1 | Byte on in_data is valid |
| in_sof | input | 1 | Valid byte is the first of a frame |
| in_data | input | 8 | Received byte |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The assertions assume that in_sof is only ever raised together with in_valid. They also assume that the configuration the verdict depends on is stable in the cycle the sixth byte is taken, since each property compares the verdict with the registered settings of that earlier cycle. The bench writes registers only between headers and always drives in_sof with in_valid. It inserts idle gaps and mid-header restarts only on a quiet configuration, so the stimulus stays inside those assumptions.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320,
  parameter int          HDR_LEN  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_data,
  output logic        dec_valid,
  output logic        dec_accept
);
  localparam int CW = $clog2(HDR_LEN + 1);
  localparam logic [CW-1:0] IDLE = CW'(HDR_LEN);
  localparam logic [CW-1:0] LAST = CW'(HDR_LEN - 1);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? CRC_POLY : 32'h0);
    return r;
  endfunction

  logic        en_q, pm_q, he_q;
  logic [15:0] st_q [3];
  logic [15:0] hash_q [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pm_q <= 1'b0;
      he_q <= 1'b0;
      for (int i = 0; i < 3; i++) st_q[i] <= '0;
      for (int i = 0; i < 4; i++) hash_q[i] <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0: begin
          en_q <= reg_wdata[0];
          pm_q <= reg_wdata[6];
          he_q <= reg_wdata[11];
        end
        4'd1, 4'd2, 4'd3: st_q[reg_addr[1:0] - 2'd1] <= reg_wdata;
        4'd4, 4'd5, 4'd6, 4'd7: hash_q[reg_addr[1:0]] <= reg_wdata;
        default: ;
      endcase
    end
  end

  logic [CW-1:0] cnt_q;
  logic [31:0]   crc_q;
  logic [39:0]   sh_q;

  wire         start   = in_valid && in_sof;
  wire         advance = in_valid && !in_sof && (cnt_q < IDLE);
  wire         fire    = in_valid && !in_sof && (cnt_q == LAST);
  wire  [31:0] crc_nxt = crc_byte(start ? 32'hFFFFFFFF : crc_q, in_data);
  wire  [47:0] hdr     = {sh_q, in_data};
  wire  [47:0] station = {st_q[0], st_q[1], st_q[2]};
  wire  [5:0]  hidx    = crc_nxt[31:26];
  wire  [15:0] hword   = hash_q[2'd3 - hidx[5:4]];
  wire         hhit    = he_q && hword[hidx[3:0]];
  wire         accept  = en_q && (pm_q || (hdr == station) || (&hdr) || hhit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= IDLE;
      crc_q <= 32'hFFFFFFFF;
      sh_q  <= '0;
    end else if (start || advance) begin
      cnt_q <= start ? CW'(1) : cnt_q + CW'(1);
      crc_q <= crc_nxt;
      sh_q  <= {sh_q[31:0], in_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= fire;
      dec_accept <= fire && accept;
    end
  end

  AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !$past(en_q) |-> !dec_accept); // R1
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(en_q && pm_q) |-> dec_accept); // R2
  AST_STATION_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(en_q && (hdr == station)) |-> dec_accept); // R3
  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(en_q && (&hdr)) |-> dec_accept); // R4
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R8
  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && !in_sof)); // R8
  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_accept); // R8
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= IDLE); // R9
endmodule

// File: tb/tb_rx_dest_filter.sv
`timescale 1ns/1ps
module tb_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        dec_valid, dec_accept;

  always #4 clk = ~clk;

  rx_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  logic last_acc = 1'b0;

  always @(negedge clk) if (dec_valid) begin
    pulses = pulses + 1;
    last_acc = dec_accept;
  end

  localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC1   = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC2   = 48'h33_33_00_00_00_FB;
  localparam logic [47:0] UNI   = 48'h01_23_45_67_89_AB;
  localparam int NV = 13;
  // {config, destination, hash mode (0 none, 1 only target bit, 2 all but target), expected}
  localparam logic [66:0] VEC [NV] = '{
    {16'h0001, STA,                  2'd0, 1'b1},
    {16'h0001, 48'h02_11_22_33_44_56, 2'd0, 1'b0},
    {16'h0001, BCAST,                2'd0, 1'b1},
    {16'h0000, BCAST,                2'd0, 1'b0},
    {16'h0040, UNI,                  2'd0, 1'b0},
    {16'h0041, UNI,                  2'd0, 1'b1},
    {16'h0801, MC1,                  2'd1, 1'b1},
    {16'h0801, MC1,                  2'd2, 1'b0},
    {16'h0001, MC1,                  2'd1, 1'b0},
    {16'h0801, MC2,                  2'd1, 1'b1},
    {16'h0801, 48'h11_02_33_22_55_44, 2'd0, 1'b0},
    {16'h0801, BCAST,                2'd0, 1'b1},
    {16'h0841, UNI,                  2'd0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_index(input logic [47:0] d);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++)
        c = (c >> 1) ^ ((c[0] ^ d[47 - 8*b + i - 7]) ? 32'hEDB88320 : 32'h0);
    return c[31:26];
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_hash(input logic [1:0] mode, input logic [47:0] d);
    logic [5:0] ix;
    logic [15:0] w;
    ix = ref_index(d);
    for (int j = 0; j < 4; j++) begin
      w = (mode == 2'd2) ? 16'hFFFF : 16'h0000;
      if (mode != 2'd0 && (4 + j) == (7 - int'(ix[5:4])))
        w = (mode == 2'd1) ? (16'h1 << ix[3:0]) : ~(16'h1 << ix[3:0]);
      wr(4'(4 + j), w);
    end
  endtask

  task automatic send_hdr(input logic [47:0] d, input int gap, output logic v, output logic a);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_data = d[47 - 8*i -: 8];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    v = dec_valid; a = dec_accept;
  endtask

  task automatic send_bytes(input int n, input logic sof_first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = sof_first && (i == 0); in_data = 8'(8'hA0 + i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, a;
    logic [66:0] e;
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R10 outputs in reset", {dec_valid, dec_accept}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_valid == 1'b0, "R10 outputs after reset", dec_valid, 0);

    send_hdr(BCAST, 0, v, a);
    chk(v == 1'b1 && a == 1'b0, "R10 reject with cleared config", {v, a}, 2'b10);

    wr(4'd1, STA[47:32]);
    wr(4'd2, STA[31:16]);
    wr(4'd3, STA[15:0]);

    for (int n = 0; n < NV; n++) begin
      e = VEC[n];
      set_hash(e[2:1], e[50:3]);
      wr(4'd0, e[66:51]);
      send_hdr(e[50:3], 0, v, a);
      chk(v == 1'b1, $sformatf("R8 pulse vector %0d", n), v, 1);
      chk(a == e[0], $sformatf("R1 R2 R3 R4 R5 R6 R7 verdict vector %0d", n), a, e[0]);
    end

    // R7: target bit placed in the non-reversed word must not accept
    begin
      logic [5:0] ix;
      ix = ref_index(MC1);
      set_hash(2'd0, MC1);
      wr(4'(4 + int'(ix[5:4])), 16'h1 << ix[3:0]);
      if (ix[5:4] == 2'd0 || ix[5:4] == 2'd3) wr(4'(4 + int'(ix[5:4])), 16'h0);
      if (ix[5:4] == 2'd0 || ix[5:4] == 2'd3) wr(4'd5, 16'h1 << ix[3:0]);
      wr(4'd0, 16'h0801);
      send_hdr(MC1, 0, v, a);
      chk(a == 1'b0, "R7 wrong word order rejected", a, 0);
    end

    // R8: trailing bytes give no further pulse
    wr(4'd0, 16'h0001);
    send_hdr(STA, 0, v, a);
    chk(v == 1'b1 && a == 1'b1, "R8 header verdict", {v, a}, 2'b11);
    #1 pulses = 0;
    send_bytes(10, 1'b0);
    @(negedge clk);
    #1 chk(pulses == 0, "R8 no pulse on trailing bytes", pulses, 0);

    // R9: restart mid header and gaps between bytes
    #1 pulses = 0;
    send_bytes(3, 1'b1);
    send_hdr(STA, 2, v, a);
    @(negedge clk);
    #1 chk(pulses == 1, "R9 one pulse after restart", pulses, 1);
    chk(last_acc == 1'b1, "R9 restarted header accepted", last_acc, 1);

    // R11: writes to unused addresses are ignored
    wr(4'd8, 16'h0000);
    wr(4'd9, 16'h0000);
    wr(4'd12, 16'h0000);
    wr(4'd15, 16'h0000);
    send_hdr(STA, 0, v, a);
    chk(v == 1'b1 && a == 1'b1, "R11 unused writes ignored", {v, a}, 2'b11);

    // R1: enable cleared with promiscuous and hash set
    wr(4'd0, 16'h0840);
    send_hdr(STA, 0, v, a);
    chk(v == 1'b1 && a == 1'b0, "R1 disabled rejects station", {v, a}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule